// File: doc/BRIEF.md
# System Register Memory Redirect Unit

This unit sits in a processor's system-register access path. It decides whether a guest-kernel-level register access should be turned into a 64-bit load or store to a hypervisor-owned memory page. If it does, the register itself is not touched. Each register number selects a 16-bit descriptor from a reloadable table. The low bits of the descriptor give a byte offset into the page. The top two bits restrict the redirect to one value of the nested-variant control bit.

An access that is redirected becomes one aligned 64-bit transfer on a valid/ready memory request port. Its address is the page base plus the offset. Byte order comes from the hypervisor endianness control and the translation regime comes from the host-mode control, each sampled when the request is accepted. A read writes the loaded value back to the destination register. A write stores the source value. An access that is not redirected is handed straight back to the normal permission logic, together with its trap/undefined indication. An access that is redirected overrides that indication.

Top module: `sysreg_mem_redirect`

## Requirements
- R1: The descriptor table holds NUM_REGS 16-bit entries. Every entry is zero after reset and is rewritten through the configuration port. A zero entry never redirects.
- R2: Redirect is possible only when nested enable and redirect enable are both 1 and the entry is nonzero.
- R3: If entry bit 14 is set, the access redirects only when the variant bit is 1. This test takes priority over bit 15. If only bit 15 is set, it redirects only when the variant bit is 0. With neither bit set, it redirects for both values of the variant bit.
- R4: A redirected access ignores reqPermFault. It raises no passValid and goes to memory instead.
- R5: A non-redirected access raises passValid for one cycle, in the cycle after acceptance, with passFault equal to the reqPermFault that was accepted. It makes no memory request.
- R6: memAddr = {basePage, 12'b0} + {entry[13:3], 3'b000}, so every transfer is 64-bit aligned.
- R7: memBigEnd is the ctlBigEnd value at acceptance. When it is 1, memWrData byte k (bits 8k+7:8k) is source byte 7-k, and the read data is reversed in the same way. When it is 0, the data passes unchanged.
- R8: memHostRegime is the ctlHostMode value at acceptance. Later changes to the controls do not alter a request already accepted.
- R9: memReqValid rises in the cycle after a redirected acceptance. Address, data and attributes stay stable until memReqReady is seen. reqReady is 0 while an access is outstanding.
- R10: One cycle after memRespValid arrives for an outstanding access, doneValid pulses. A read without error also pulses wbValid with the loaded data. A response while idle has no effect.
- R11: If memRespErr is 1, faultValid pulses with faultAddr equal to the request address, and wbValid stays 0.
- R12: memWrite is 1 for a write and 0 for a read. A write carries reqWrData, byte-ordered as in R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgWrEn | input | 1 | Write one descriptor entry |
| cfgIdx | input | IDX_W | Entry index to write |
| cfgField | input | 16 | New descriptor value |
| baseWrEn | input | 1 | Load the page base register |
| baseWrPage | input | ADDR_W-12 | Page number of the redirect page |
| ctlNestEn | input | 1 | Nested virtualization enable |
| ctlVariant | input | 1 | Nested variant bit |
| ctlRedirEn | input | 1 | Memory redirect enable |
| ctlHostMode | input | 1 | Host-mode control; selects translation regime |
| ctlBigEnd | input | 1 | Hypervisor-level endianness control |
| reqValid | input | 1 | Register access request |
| reqReady | output | 1 | Unit can accept an access |
| reqRegIdx | input | IDX_W | Register number of the access |
| reqIsRead | input | 1 | 1 = read, 0 = write |
| reqWrData | input | DATA_W | Source register value |
| reqPermFault | input | 1 | Normal check would trap or be undefined |
| passValid | output | 1 | Access handed to normal path |
| passFault | output | 1 | Trap/undefined indication for passed access |
| memReqValid | output | 1 | Memory request valid |
| memReqReady | input | 1 | Memory request accepted |
| memAddr | output | ADDR_W | Byte address, 8-byte aligned |
| memWrData | output | DATA_W | Store data in byte-lane order |
| memWrite | output | 1 | 1 = store, 0 = load |
| memBigEnd | output | 1 | Big-endian attribute |
| memHostRegime | output | 1 | 1 = hypervisor-and-host regime, 0 = hypervisor regime |
| memRespValid | input | 1 | Memory response |
| memRespData | input | DATA_W | Load data in byte-lane order |
| memRespErr | input | 1 | Memory fault |
| doneValid | output | 1 | Redirected access complete |
| wbValid | output | 1 | Write destination register |
| wbData | output | DATA_W | Value for the destination register |
| faultValid | output | 1 | Redirected access faulted |
| faultAddr | output | ADDR_W | Address of the faulting access |

## Verification
The bench sweeps all sixteen table entries against both variant values and all four nested/redirect enable combinations. A design that decoded the two flag bits the wrong way round, or that let bit 15 override bit 14, would redirect the wrong half of those cases. Each access is issued with the permission fault raised, so a design that still trapped a redirected access would show a stray passValid. The bench changes the byte-order and regime controls right after acceptance and stalls memReqReady. A design that sampled the controls late, or let the request drift, would show changed attributes or a changed address. The bench also uses an offset that carries into the page bits, an error response on a read, and a response sent while idle. These catch a truncated adder, writeback on a fault, and spurious completions.

// File: rtl/srr_pkg.sv
package srr_pkg;
  localparam int unsigned FIELD_W = 16;
  localparam int unsigned FLAG_V1 = FIELD_W - 2;  // redirect only if variant==1
  localparam int unsigned FLAG_V0 = FIELD_W - 1;  // redirect only if variant==0

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } srr_state_e;

  typedef struct packed {
    logic captureReq;
    logic captureResp;
  } srr_strobe_t;

  // Per-entry redirect condition; the variant-1 flag is tested first.
  function automatic logic entryHit(input logic [FIELD_W-1:0] field, input logic variant);
    logic hit;
    if (field == '0)          hit = 1'b0;
    else if (field[FLAG_V1])  hit = variant;
    else if (field[FLAG_V0])  hit = ~variant;
    else                      hit = 1'b1;
    return hit;
  endfunction
endpackage

// File: rtl/srr_desc_table.sv
module srr_desc_table
  import srr_pkg::*;
#(
  parameter int unsigned NUM_REGS = 16,
  localparam int unsigned IDX_W = $clog2(NUM_REGS)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [IDX_W-1:0]   wrIdx,
  input  logic [FIELD_W-1:0] wrField,
  input  logic [IDX_W-1:0]   rdIdx,
  output logic [FIELD_W-1:0] rdField
);
  logic [FIELD_W-1:0] entries [NUM_REGS];

  for (genvar e = 0; e < NUM_REGS; e++) begin : g_entry
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                  entries[e] <= '0;
      else if (wrEn && wrIdx == IDX_W'(e))        entries[e] <= wrField;
    end
  end

  assign rdField = entries[rdIdx];
endmodule

// File: rtl/srr_ctrl.sv
module srr_ctrl
  import srr_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic               reqPermFault,
  input  logic [FIELD_W-1:0] field,
  input  logic               ctlNestEn,
  input  logic               ctlRedirEn,
  input  logic               ctlVariant,
  input  logic               memReqReady,
  input  logic               memRespValid,
  input  logic               memRespErr,
  input  logic               memWrite,
  output logic               reqReady,
  output logic               memReqValid,
  output srr_strobe_t        strobe,
  output logic               passValid,
  output logic               passFault,
  output logic               doneValid,
  output logic               wbValid,
  output logic               faultValid
);
  srr_state_e state, stateNext;
  logic accept, hit;

  always_comb begin
    hit    = ctlNestEn & ctlRedirEn & entryHit(field, ctlVariant);
    accept = reqValid & (state == ST_IDLE);
    strobe.captureReq  = accept & hit;
    strobe.captureResp = (state == ST_WAIT) & memRespValid;
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:  if (strobe.captureReq)  stateNext = ST_ISSUE;
      ST_ISSUE: if (memReqReady)        stateNext = ST_WAIT;
      ST_WAIT:  if (memRespValid)       stateNext = ST_IDLE;
      default:                          stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      passValid  <= 1'b0;
      passFault  <= 1'b0;
      doneValid  <= 1'b0;
      wbValid    <= 1'b0;
      faultValid <= 1'b0;
    end else begin
      state      <= stateNext;
      passValid  <= accept & ~hit;
      passFault  <= accept & ~hit & reqPermFault;
      doneValid  <= strobe.captureResp;
      wbValid    <= strobe.captureResp & ~memWrite & ~memRespErr;
      faultValid <= strobe.captureResp & memRespErr;
    end
  end

  assign reqReady    = (state == ST_IDLE);
  assign memReqValid = (state == ST_ISSUE);

  p_hold_req_r9: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memReqReady |=> memReqValid);
  p_busy_block_r9: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> !reqReady);
  p_override_r4: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady && hit |=> !passValid && memReqValid);
  p_pass_excl_r5: assert property (@(posedge clk) disable iff (!rstN)
    passValid |-> !memReqValid && !doneValid);
  p_done_after_resp_r10: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |-> $past(memRespValid));
  p_fault_no_wb_r11: assert property (@(posedge clk) disable iff (!rstN)
    faultValid |-> !wbValid && doneValid);
endmodule

// File: rtl/srr_datapath.sv
module srr_datapath
  import srr_pkg::*;
#(
  parameter int unsigned ADDR_W    = 64,
  parameter int unsigned DATA_W    = 64,
  parameter int unsigned PAGE_BITS = 12,
  localparam int unsigned NBYTES   = DATA_W / 8,
  localparam int unsigned OFFW_W   = FIELD_W - 5
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  srr_strobe_t               strobe,
  input  logic                      baseWrEn,
  input  logic [ADDR_W-PAGE_BITS-1:0] baseWrPage,
  input  logic [OFFW_W-1:0]         offWord,
  input  logic                      reqIsRead,
  input  logic [DATA_W-1:0]         reqWrData,
  input  logic                      ctlBigEnd,
  input  logic                      ctlHostMode,
  input  logic [DATA_W-1:0]         memRespData,
  output logic [ADDR_W-1:0]         memAddr,
  output logic [DATA_W-1:0]         memWrData,
  output logic                      memWrite,
  output logic                      memBigEnd,
  output logic                      memHostRegime,
  output logic [DATA_W-1:0]         wbData
);
  logic [ADDR_W-PAGE_BITS-1:0] basePageQ;
  logic [DATA_W-1:0] wrSwap, rdSwap;
  logic [ADDR_W-1:0] offExt;

  for (genvar b = 0; b < NBYTES; b++) begin : g_swap
    assign wrSwap[8*b +: 8] = reqWrData[8*(NBYTES-1-b) +: 8];
    assign rdSwap[8*b +: 8] = memRespData[8*(NBYTES-1-b) +: 8];
  end

  assign offExt = {{(ADDR_W-OFFW_W-3){1'b0}}, offWord, 3'b000};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) basePageQ <= '0;
    else if (baseWrEn) basePageQ <= baseWrPage;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      memAddr       <= '0;
      memWrData     <= '0;
      memWrite      <= 1'b0;
      memBigEnd     <= 1'b0;
      memHostRegime <= 1'b0;
    end else if (strobe.captureReq) begin
      memAddr       <= {basePageQ, {PAGE_BITS{1'b0}}} + offExt;
      memWrData     <= ctlBigEnd ? wrSwap : reqWrData;
      memWrite      <= ~reqIsRead;
      memBigEnd     <= ctlBigEnd;
      memHostRegime <= ctlHostMode;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                    wbData <= '0;
    else if (strobe.captureResp)  wbData <= memBigEnd ? rdSwap : memRespData;
  end

  p_addr_aligned_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.captureResp |-> memAddr[2:0] == 3'b000);
endmodule

// File: rtl/sysreg_mem_redirect.sv
module sysreg_mem_redirect
  import srr_pkg::*;
#(
  parameter int unsigned NUM_REGS  = 16,
  parameter int unsigned ADDR_W    = 64,
  parameter int unsigned DATA_W    = 64,
  parameter int unsigned PAGE_BITS = 12,
  localparam int unsigned IDX_W    = $clog2(NUM_REGS)
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        cfgWrEn,
  input  logic [IDX_W-1:0]            cfgIdx,
  input  logic [FIELD_W-1:0]          cfgField,
  input  logic                        baseWrEn,
  input  logic [ADDR_W-PAGE_BITS-1:0] baseWrPage,
  input  logic                        ctlNestEn,
  input  logic                        ctlVariant,
  input  logic                        ctlRedirEn,
  input  logic                        ctlHostMode,
  input  logic                        ctlBigEnd,
  input  logic                        reqValid,
  output logic                        reqReady,
  input  logic [IDX_W-1:0]            reqRegIdx,
  input  logic                        reqIsRead,
  input  logic [DATA_W-1:0]           reqWrData,
  input  logic                        reqPermFault,
  output logic                        passValid,
  output logic                        passFault,
  output logic                        memReqValid,
  input  logic                        memReqReady,
  output logic [ADDR_W-1:0]           memAddr,
  output logic [DATA_W-1:0]           memWrData,
  output logic                        memWrite,
  output logic                        memBigEnd,
  output logic                        memHostRegime,
  input  logic                        memRespValid,
  input  logic [DATA_W-1:0]           memRespData,
  input  logic                        memRespErr,
  output logic                        doneValid,
  output logic                        wbValid,
  output logic [DATA_W-1:0]           wbData,
  output logic                        faultValid,
  output logic [ADDR_W-1:0]           faultAddr
);
  logic [FIELD_W-1:0] curField;
  srr_strobe_t strobe;

  srr_desc_table #(.NUM_REGS(NUM_REGS)) table_i (
    .clk(clk), .rstN(rstN),
    .wrEn(cfgWrEn), .wrIdx(cfgIdx), .wrField(cfgField),
    .rdIdx(reqRegIdx), .rdField(curField)
  );

  srr_ctrl ctrl_i (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqPermFault(reqPermFault), .field(curField),
    .ctlNestEn(ctlNestEn), .ctlRedirEn(ctlRedirEn), .ctlVariant(ctlVariant),
    .memReqReady(memReqReady), .memRespValid(memRespValid), .memRespErr(memRespErr),
    .memWrite(memWrite),
    .reqReady(reqReady), .memReqValid(memReqValid), .strobe(strobe),
    .passValid(passValid), .passFault(passFault), .doneValid(doneValid),
    .wbValid(wbValid), .faultValid(faultValid)
  );

  srr_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_BITS(PAGE_BITS)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .baseWrEn(baseWrEn), .baseWrPage(baseWrPage),
    .offWord(curField[FIELD_W-3:3]),
    .reqIsRead(reqIsRead), .reqWrData(reqWrData),
    .ctlBigEnd(ctlBigEnd), .ctlHostMode(ctlHostMode),
    .memRespData(memRespData),
    .memAddr(memAddr), .memWrData(memWrData), .memWrite(memWrite),
    .memBigEnd(memBigEnd), .memHostRegime(memHostRegime), .wbData(wbData)
  );

  assign faultAddr = memAddr;

  p_stable_req_r9: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memReqReady |=> $stable(memAddr) && $stable(memWrData)
      && $stable(memBigEnd) && $stable(memHostRegime) && $stable(memWrite));
endmodule

// File: tb/sysreg_mem_redirect_tb_top.sv
module sysreg_mem_redirect_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2 clk = ~clk;

  logic cfgWrEn = 0; logic [3:0] cfgIdx = 0; logic [15:0] cfgField = 0;
  logic baseWrEn = 0; logic [51:0] baseWrPage = 0;
  logic ctlNestEn = 0, ctlVariant = 0, ctlRedirEn = 0, ctlHostMode = 0, ctlBigEnd = 0;
  logic reqValid = 0, reqReady; logic [3:0] reqRegIdx = 0; logic reqIsRead = 0;
  logic [63:0] reqWrData = 0; logic reqPermFault = 0;
  logic passValid, passFault, memReqValid; logic memReqReady = 0;
  logic [63:0] memAddr, memWrData; logic memWrite, memBigEnd, memHostRegime;
  logic memRespValid = 0; logic [63:0] memRespData = 0; logic memRespErr = 0;
  logic doneValid, wbValid, faultValid; logic [63:0] wbData, faultAddr;

  sysreg_mem_redirect dut_i (.*);

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [15:0] fields [16];
  logic [51:0] curPage;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] bswap(input logic [63:0] d);
    logic [63:0] r;
    for (int b = 0; b < 8; b++) r[8*b +: 8] = d[8*(7-b) +: 8];
    return r;
  endfunction

  function automatic bit expHit(input logic [15:0] f);
    if (!(ctlNestEn && ctlRedirEn) || f == 0) return 0;
    if (f[14]) return ctlVariant;
    if (f[15]) return !ctlVariant;
    return 1;
  endfunction

  task automatic loadEntry(input int i, input logic [15:0] f);
    @(negedge clk); cfgWrEn = 1; cfgIdx = 4'(i); cfgField = f; fields[i] = f;
    @(negedge clk); cfgWrEn = 0;
  endtask

  task automatic access(input int idx, input bit rd, input logic [63:0] wd,
                        input int stall, input logic [63:0] rdata, input bit err);
    bit eh, be, host;
    logic [63:0] ea;
    @(negedge clk);
    eh = expHit(fields[idx]); be = ctlBigEnd; host = ctlHostMode;
    ea = {curPage, 12'h000} + 64'(fields[idx] & 16'h3FF8);
    chk(reqReady === 1'b1, "R9 ready idle", 64'(reqReady), 64'd1);
    reqValid = 1; reqRegIdx = 4'(idx); reqIsRead = rd; reqWrData = wd; reqPermFault = 1'b1;
    @(negedge clk);
    reqValid = 0; reqPermFault = 0;
    ctlBigEnd = ~be; ctlHostMode = ~host;  // late changes must not matter (R8)
    if (!eh) begin
      chk(passValid === 1'b1 && passFault === 1'b1, "R5 pass", 64'({passValid, passFault}), 64'd3);
      chk(memReqValid === 1'b0, "R2 R3 no redirect", 64'(memReqValid), 64'd0);
      @(negedge clk);
      chk(passValid === 1'b0, "R5 pulse", 64'(passValid), 64'd0);
      ctlBigEnd = be; ctlHostMode = host;
      return;
    end
    chk(memReqValid === 1'b1 && passValid === 1'b0, "R4 redirect overrides",
        64'({memReqValid, passValid}), 64'd2);
    chk(memAddr === ea, "R6 address", memAddr, ea);
    chk(memWrite === !rd, "R12 direction", 64'(memWrite), 64'(!rd));
    if (!rd) chk(memWrData === (be ? bswap(wd) : wd), "R7 R12 store data",
                 memWrData, be ? bswap(wd) : wd);
    chk(memBigEnd === be, "R7 byte order", 64'(memBigEnd), 64'(be));
    chk(memHostRegime === host, "R8 regime", 64'(memHostRegime), 64'(host));
    for (int s = 0; s < stall; s++) begin
      @(negedge clk);
      chk(memReqValid === 1'b1 && memAddr === ea && reqReady === 1'b0, "R9 hold",
          memAddr, ea);
    end
    memReqReady = 1;
    @(negedge clk);
    memReqReady = 0;
    chk(memReqValid === 1'b0, "R9 handshake", 64'(memReqValid), 64'd0);
    memRespValid = 1; memRespData = rdata; memRespErr = err;
    @(negedge clk);
    memRespValid = 0; memRespErr = 0;
    chk(doneValid === 1'b1, "R10 done", 64'(doneValid), 64'd1);
    if (err) begin
      chk(faultValid === 1'b1 && wbValid === 1'b0, "R11 fault no wb",
          64'({faultValid, wbValid}), 64'd2);
      chk(faultAddr === ea, "R11 fault address", faultAddr, ea);
    end else begin
      chk(wbValid === rd && faultValid === 1'b0, "R10 wb strobe",
          64'({wbValid, faultValid}), 64'({rd, 1'b0}));
      if (rd) chk(wbData === (be ? bswap(rdata) : rdata), "R7 R10 load data",
                  wbData, be ? bswap(rdata) : rdata);
    end
    @(negedge clk);
    chk(doneValid === 1'b0, "R10 pulse", 64'(doneValid), 64'd0);
    ctlBigEnd = be; ctlHostMode = host;
  endtask

  initial begin
    for (int i = 0; i < 16; i++) fields[i] = 16'h0;
    curPage = 52'h0;
    repeat (3) @(negedge clk);
    chk(memReqValid === 0 && passValid === 0 && doneValid === 0 && wbValid === 0,
        "reset outputs", 64'({memReqValid, passValid, doneValid, wbValid}), 64'd0);
    rstN = 1;
    // R1: empty table never redirects
    ctlNestEn = 1; ctlRedirEn = 1;
    for (int i = 0; i < 16; i++) access(i, 1, 64'h0, 0, 64'h0, 0);
    @(negedge clk); baseWrEn = 1; baseWrPage = 52'hA_BCDE_F012_3456; curPage = baseWrPage;
    @(negedge clk); baseWrEn = 0;
    for (int i = 0; i < 16; i++) begin
      logic [15:0] f;
      case (i)
        0: f = 16'h0000; 1: f = 16'h0020; 2: f = 16'h4028; 3: f = 16'h8028;
        4: f = 16'hC030; 5: f = 16'h0007; 6: f = 16'h3FF8;
        default: f = 16'(i*8 + 256) | ((i % 4 == 1) ? 16'h4000 : (i % 4 == 2) ? 16'h8000 : 16'h0);
      endcase
      loadEntry(i, f);
    end
    // R2 R3 R4: sweep variant, enables, entries
    for (int v = 0; v < 2; v++)
      for (int c = 0; c < 4; c++)
        for (int i = 0; i < 16; i++) begin
          ctlVariant = v[0]; ctlNestEn = c[0]; ctlRedirEn = c[1];
          ctlBigEnd = i[0] ^ v[0]; ctlHostMode = i[1];
          access(i, i[2], 64'h0123_4567_89AB_CDEF ^ 64'(i * 37 + c),
                 i % 3, 64'hFEDC_BA98_7654_3210 + 64'(i), (i == 9) && i[2] == 0 ? 1'b0 : (i == 13));
        end
    // R11: read that faults
    ctlNestEn = 1; ctlRedirEn = 1; ctlVariant = 0;
    access(1, 1, 64'h0, 1, 64'h1111_2222_3333_4444, 1);
    // R10: response while idle ignored
    @(negedge clk); memRespValid = 1; memRespData = 64'hDEAD;
    @(negedge clk); memRespValid = 0;
    chk(doneValid === 0 && wbValid === 0, "R10 idle response", 64'({doneValid, wbValid}), 64'd0);
    // R1: reload entries
    loadEntry(0, 16'h0040);
    access(0, 0, 64'h5555_AAAA_0000_FFFF, 0, 64'h0, 0);
    loadEntry(1, 16'h0000);
    access(1, 0, 64'h1, 0, 64'h0, 0);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule